// File: doc/BRIEF.md
# Companding Successive-Approximation Encoder Sequencer

This block is the digital sequencer of a segmented mu-255 PCM encoder. The encoder is built around a switched capacitor array and a resistor divider. Each sample strobe starts one conversion, and the conversion runs through these phases in order:

- sample phase;
- sign decision;
- chord search, which moves forward one capacitor at a time;
- successive approximation of the four step bits, using resistor taps.

Every phase lasts a fixed number of clocks so the comparator can settle. The comparator decision is registered on the last clock of the phase. The block drives the switch controls (sampling, bottom-plate reference select, capacitor count and tap index) and reads one comparator bit per phase.

When the conversion ends, the block assembles sign, chord and step into a raw byte. It inverts that byte in the mu-law manner and replaces an all-zero result with a small non-zero code. The word is presented together with a one-clock done pulse.

Top module: `muSarSequencer`

## Requirements
- R1: After reset, all phase outputs are low, `done` is low, `plateGround` is low and `pcmWord` reads 8'hFF.
- R2: A high `sampleStrobe` while idle starts a conversion. The conversion runs 2 + K + 4 phases of SETTLE_CYCLES clocks each, where K = chord+1 for chords 0..6 and K = 7 for chord 7. `done` rises exactly (6+K)*SETTLE_CYCLES clock edges after the starting edge.
- R3: The sign phase reads the comparator once. A high reading means the sample is non-negative and gives raw sign bit 0. A low reading gives raw sign bit 1, which is bit 7 of the raw byte.
- R4: During the chord and step phases, `plateGround` is 1 for a non-negative sample and 0 for a negative one. It holds that value until the next conversion starts.
- R5: The chord search starts with `capCount`=0. On each high reading `capCount` goes up by one. The first low reading ends the search, and the chord is then the current `capCount`, held in raw bits 6:4.
- R6: If every chord reading is high, the chord saturates at 7 after seven chord phases.
- R7: The step bits (raw bits 3:0) are resolved MSB first by successive approximation. During each step phase `tapIdx` equals twice the trial step value, so it stays even and in the range 0..32. The first trial is 16.
- R8: `pcmWord` is the bitwise inverse of the raw byte. When that inverse would be 8'h00, the value 8'h02 is output instead.
- R9: `sampleStrobe` has no effect while a conversion is in progress.
- R10: `done` is high for exactly one clock. `pcmWord` holds its value until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | Starts a conversion when idle |
| cmpAbove | input | 1 | Comparator: input at or above the trial level |
| sampleOn | output | 1 | Sample switch closed (sample phase) |
| plateGround | output | 1 | Bottom plates referenced to ground (positive sample) |
| chordPhase | output | 1 | Chord search in progress |
| stepPhase | output | 1 | Step approximation in progress |
| capCount | output | 3 | Capacitors switched / selected chord |
| tapIdx | output | 6 | Resistor-string tap driving the selected capacitor |
| done | output | 1 | One-clock completion pulse |
| pcmWord | output | 8 | Encoded, inverted mu-255 word |

## Verification
The assertions check several properties on every cycle:
- at most one phase output is high at a time;
- the chord search leaves on its first low comparator reading;
- the chord count never goes backwards during the search;
- the plate reference does not move once the search has begun;
- each step tap is even and within range;
- `done` is a single-clock pulse that never carries an all-zero word.

Only the bench's scenarios can show the rest. Those are the full code mapping against a behavioural comparator for positive, negative, tiny and overloaded samples, the exact phase count that sets the latency, chord saturation, zero-code substitution and the rejection of a strobe that arrives mid-conversion.

// File: rtl/muSarPkg.sv
package muSarPkg;
  localparam int ChordW = 3;
  localparam int StepW  = 4;
  localparam int WordW  = 1 + ChordW + StepW;
  localparam int TapW   = StepW + 2;
  localparam int MaxChord = (1 << ChordW) - 1;
  localparam logic [WordW-1:0] ZeroSubst = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAMPLE, ST_SIGN, ST_CHORD, ST_STEP
  } seqState_t;

  typedef struct packed {
    logic             clearAll;
    logic             latchSign;
    logic             chordEval;
    logic             stepEval;
    logic [1:0]       stepBit;
    logic             finish;
  } seqStrobes_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import muSarPkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic              cmpAbove,
  input  logic [ChordW-1:0] trialChord,
  output seqStrobes_t       stb,
  output seqState_t         state
);
  localparam int CntW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(SETTLE_CYCLES - 1);

  logic [CntW-1:0] settleCnt;
  logic [1:0]      bitIdx;
  logic            lastTick;

  assign lastTick = (settleCnt == LastCnt);

  always_comb begin
    stb           = '0;
    stb.clearAll  = (state == ST_IDLE) && startStrobe;
    stb.latchSign = (state == ST_SIGN) && lastTick;
    stb.chordEval = (state == ST_CHORD) && lastTick;
    stb.stepEval  = (state == ST_STEP) && lastTick;
    stb.stepBit   = bitIdx;
    stb.finish    = (state == ST_STEP) && lastTick && (bitIdx == 2'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      bitIdx    <= 2'd3;
    end else if (state == ST_IDLE) begin
      settleCnt <= '0;
      bitIdx    <= 2'd3;
      if (startStrobe) state <= ST_SAMPLE;
    end else if (lastTick) begin
      settleCnt <= '0;
      unique case (state)
        ST_SAMPLE: state <= ST_SIGN;
        ST_SIGN:   state <= ST_CHORD;
        ST_CHORD:  if (!cmpAbove || trialChord == ChordW'(MaxChord - 1)) state <= ST_STEP;
        ST_STEP: begin
          if (bitIdx == 2'd0) state <= ST_IDLE;
          else bitIdx <= bitIdx - 2'd1;
        end
        default:   state <= ST_IDLE;
      endcase
    end else begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  AST_CHORD_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHORD && lastTick && !cmpAbove) |=> (state == ST_STEP)); // R5
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_STEP) |=> (state != ST_IDLE)); // R9
endmodule

// File: rtl/sarData.sv
module sarData
  import muSarPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       stb,
  input  logic              cmpAbove,
  input  logic              stepActive,
  input  logic              searchActive,
  output logic              plateGround,
  output logic [ChordW-1:0] chordReg,
  output logic [TapW-1:0]   tapIdx,
  output logic              done,
  output logic [WordW-1:0]  pcmWord
);
  logic             signNeg;
  logic [StepW-1:0] stepReg;
  logic [StepW-1:0] trialStep;
  logic [WordW-1:0] rawWord;
  logic [WordW-1:0] invWord;
  logic [StepW-1:0] stepNext;

  always_comb begin
    trialStep = stepReg;
    trialStep[stb.stepBit] = 1'b1;
    stepNext  = stepReg;
    stepNext[stb.stepBit] = cmpAbove;
  end

  assign tapIdx  = stepActive ? {1'b0, trialStep, 1'b0} : '0;
  assign rawWord = {signNeg, chordReg, stb.stepEval ? stepNext : stepReg};
  assign invWord = ~rawWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      signNeg     <= 1'b0;
      plateGround <= 1'b0;
      chordReg    <= '0;
      stepReg     <= '0;
      done        <= 1'b0;
      pcmWord     <= '1;
    end else begin
      done <= 1'b0;
      if (stb.clearAll) begin
        signNeg     <= 1'b0;
        plateGround <= 1'b0;
        chordReg    <= '0;
        stepReg     <= '0;
      end
      if (stb.latchSign) begin
        signNeg     <= !cmpAbove;
        plateGround <= cmpAbove;
      end
      if (stb.chordEval && cmpAbove && chordReg != ChordW'(MaxChord))
        chordReg <= chordReg + 1'b1;
      if (stb.stepEval) stepReg <= stepNext;
      if (stb.finish) begin
        done    <= 1'b1;
        pcmWord <= (invWord == '0) ? ZeroSubst : invWord;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_NO_ZERO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pcmWord != '0)); // R8
  AST_PLATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((searchActive || stepActive) && $past(searchActive || stepActive)) |-> $stable(plateGround)); // R4
  AST_CHORD_MONO: assert property (@(posedge clk) disable iff (!rstN)
    (searchActive && $past(searchActive)) |-> (chordReg >= $past(chordReg))); // R5
  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stepActive |-> (tapIdx <= 6'd32 && !tapIdx[0])); // R7
endmodule

// File: rtl/muSarSequencer.sv
module muSarSequencer
  import muSarPkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleStrobe,
  input  logic        cmpAbove,
  output logic        sampleOn,
  output logic        plateGround,
  output logic        chordPhase,
  output logic        stepPhase,
  output logic [2:0]  capCount,
  output logic [5:0]  tapIdx,
  output logic        done,
  output logic [7:0]  pcmWord
);
  seqStrobes_t stb;
  seqState_t   state;

  assign sampleOn   = (state == ST_SAMPLE);
  assign chordPhase = (state == ST_CHORD);
  assign stepPhase  = (state == ST_STEP);

  seqCtrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .startStrobe(sampleStrobe), .cmpAbove(cmpAbove),
    .trialChord(capCount), .stb(stb), .state(state)
  );

  sarData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpAbove(cmpAbove),
    .stepActive(stepPhase), .searchActive(chordPhase),
    .plateGround(plateGround), .chordReg(capCount), .tapIdx(tapIdx),
    .done(done), .pcmWord(pcmWord)
  );

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleOn, chordPhase, stepPhase})); // R2
endmodule

// File: tb/sim_muSarSequencer.sv
module sim_muSarSequencer;
  localparam int S = 4;
  localparam int NV = 12;
  localparam int signed VEC [NV] = '{0, 5, -5, 31, -100, 477, 1000, -3000,
                                     8000, 9000, -9000, -8158};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic cmpAbove;
  logic sampleOn, plateGround, chordPhase, stepPhase, done;
  logic [2:0] capCount;
  logic [5:0] tapIdx;
  logic [7:0] pcmWord;
  int signed inX = 0;
  int passCnt = 0;
  int totalCnt = 0;

  always #4 clk = ~clk;

  muSarSequencer #(.SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .cmpAbove(cmpAbove),
    .sampleOn(sampleOn), .plateGround(plateGround), .chordPhase(chordPhase),
    .stepPhase(stepPhase), .capCount(capCount), .tapIdx(tapIdx),
    .done(done), .pcmWord(pcmWord)
  );

  function automatic int biasedMag(int signed x);
    int m = (x < 0) ? -x : x;
    if (m > 8158) m = 8158;
    return m + 33;
  endfunction

  // behavioural comparator
  always_comb begin
    if (stepPhase)       cmpAbove = biasedMag(inX) >= ((32 + int'(tapIdx)) << capCount);
    else if (chordPhase) cmpAbove = biasedMag(inX) >= (1 << (int'(capCount) + 6));
    else                 cmpAbove = (inX >= 0);
  end

  function automatic int expChord(int signed x);
    int b = biasedMag(x);
    int c = 0;
    for (int k = 0; k < 7; k++) if (b >= (1 << (k + 6))) c = k + 1;
    return c;
  endfunction

  function automatic logic [7:0] expWord(int signed x);
    int c = expChord(x);
    int st = (biasedMag(x) >> (c + 1)) & 15;
    logic [7:0] raw = {(x < 0) ? 1'b1 : 1'b0, 3'(c), 4'(st)};
    return (~raw == 8'h00) ? 8'h02 : ~raw;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic runConv(input int signed x, input bit midStrobe);
    int n = 0;
    int firstCap = -1;
    int firstTap = -1;
    int plate = -1;
    int k;
    inX = x;
    @(negedge clk); sampleStrobe = 1'b1;
    @(posedge clk); #1 sampleStrobe = 1'b0;
    while (1) begin
      @(posedge clk); #1; n++;
      if (midStrobe) sampleStrobe = (n == 9);
      if (chordPhase && firstCap < 0) firstCap = capCount;
      if (stepPhase && firstTap < 0) begin firstTap = tapIdx; plate = plateGround; end
      if (done || n > 2000) break;
    end
    sampleStrobe = 1'b0;
    k = (expChord(x) < 7) ? expChord(x) + 1 : 7;
    check(n == (6 + k) * S, "R2 latency", n, (6 + k) * S);
    check(pcmWord == expWord(x), "R8/R3 word", pcmWord, expWord(x));
    check(plate == ((x >= 0) ? 1 : 0), "R4 plate", plate, (x >= 0) ? 1 : 0);
    check(firstCap == 0, "R5 first chord trial", firstCap, 0);
    check(firstTap == 16, "R7 first tap", firstTap, 16);
    @(posedge clk); #1;
    check(!done, "R10 done one clock", done, 0);
    check(pcmWord == expWord(x), "R10 word held", pcmWord, expWord(x));
    if (midStrobe) begin
      repeat (3 * S) begin
        @(posedge clk); #1;
        check(!done && !sampleOn, "R9 mid strobe ignored", done, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!done && !sampleOn && !chordPhase && !stepPhase, "R1 idle outputs", done, 0);
    check(pcmWord == 8'hFF, "R1 word reset", pcmWord, 255);
    check(plateGround == 1'b0, "R1 plate reset", plateGround, 0);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) runConv(VEC[i], 1'b0);
    // R6 saturation with positive overload
    runConv(20000, 1'b0);
    check(expChord(20000) == 7 && pcmWord == 8'h80, "R6 chord saturates", pcmWord, 128);
    // R8 zero substitution at negative full scale
    runConv(-9000, 1'b0);
    check(pcmWord == 8'h02, "R8 zero code substituted", pcmWord, 2);
    // R9 strobe during busy
    runConv(1000, 1'b1);
    runConv(-5, 1'b1);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    #1500000;
    totalCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule